// File: doc/BRIEF.md
# Clock Frequency Range Monitor

This block watches a monitored clock and decides, window after window, whether its frequency lies inside a band that software programs. A reference clock sets the window length. Over each window the block counts the edges of the monitored clock. When the window closes it compares that count with a high limit and a low limit held in bus-clock registers. A count outside the band sets a sticky flag that software clears by writing a one to it. The flags drive two interrupt outputs, each behind its own mask, and a two-bit range verdict.

Software writes the window length and both limits while checking is off, then sets the enable bit. Before it clears the enable bit again, it waits for the running bit to read one. Window results cross from the monitored domain to the bus domain through a toggle handshake, and the captured count stays stable while the bus side compares it. Each clock domain has its own reset synchronizer, fed from one asynchronous active-low reset.

Top module: `clk_freq_monitor`

## Requirements
- R1: Writing 1 to bit 0 at address 0 (control) enables checking and writing 0 disables it. Status bit 2 (running) reads 1 a few cycles after enabling and returns to 0 after disabling.
- R2: The window lasts the number of reference-clock cycles held at address 1. The edge count of every completed window is judged, so doubling the window doubles the count.
- R3: A window count strictly greater than the high limit (address 2) sets the high flag, status bit 1.
- R4: A window count strictly less than the low limit (address 3) sets the low flag, status bit 0. A count between the limits, inclusive, sets neither flag.
- R5: Writing status (address 5) clears each flag whose written bit is 1 and leaves each flag whose written bit is 0, so writing back the value read clears exactly the flags that were set.
- R6: Flags stay set until cleared, including across a disable. While checking is disabled, no flag is set.
- R7: The edge counter saturates at its all-ones value, so a monitored clock fast enough to overflow it still sets the high flag.
- R8: The mask register (address 4) has bit 0 = low synchronous, bit 1 = high synchronous, bit 2 = low asynchronous, bit 3 = high asynchronous. irq_sync is the registered OR of the flags enabled by bits 1:0. irq_async is the unregistered OR of the flags enabled by bits 3:2.
- R9: freq_state reads 00 while disabled. While enabled it reads 11 when the high flag is set and enabled by either of its mask bits, otherwise 10 when the low flag is set and enabled, otherwise 01. The high flag wins when both are set.
- R10: After reset every register reads 0. The control, window, limit and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ref_clk | input | 1 | Reference clock that times the window |
| mon_clk | input | 1 | Clock under observation |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_sync | output | 1 | Registered masked interrupt |
| irq_async | output | 1 | Unregistered masked interrupt |
| freq_state | output | 2 | Range verdict: 00 off, 01 in range, 10 low, 11 high |

## Verification
The bench pushes the monitored clock far enough above the counter's range that a wrapping counter would land back inside the band and report nothing, where a saturating one reports high. It sets both flags at once to show that the verdict favours high, and that a partial status write clears only the named flag. A design that cleared both flags, or every flag on any write, fails there. It also runs a fast clock while checking is off and reads back that no flag appeared, which catches a monitor that still updates flags after a disable. Running the same monitored clock with the window doubled moves the count across the limits, which catches a window-length register the timer ignores.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_WINDOW = 3'd1,
    ADDR_HI     = 3'd2,
    ADDR_LO     = 3'd3,
    ADDR_MASK   = 3'd4,
    ADDR_STATUS = 3'd5
  } fm_addr_e;

  typedef enum logic [1:0] {
    ST_OFF      = 2'b00,
    ST_IN_RANGE = 2'b01,
    ST_LOW      = 2'b10,
    ST_HIGH     = 2'b11
  } fm_state_e;

  localparam int FLAG_LO   = 0;
  localparam int FLAG_HI   = 1;
  localparam int STAT_RUN  = 2;
  localparam int MASK_W    = 4;
  localparam int FLAG_W    = 2;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_out = s2_q;
endmodule

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/fm_ref_timer.sv
// Reference-domain window timer: flips win_tgl once per window while enabled.
module fm_ref_timer #(
  parameter int REF_W = 16
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             en_async,
  input  logic [REF_W-1:0] win_len,
  output logic             run,
  output logic             win_tgl
);
  logic             en_r;
  logic [REF_W-1:0] cnt_q, cnt_n, last;
  logic             run_q, run_n, tgl_q, tgl_n;

  fm_sync #(.W(1)) u_en_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(en_async), .q(en_r)
  );

  // A zero length behaves as a one-cycle window.
  assign last = (win_len == '0) ? '0 : win_len - 1'b1;

  always_comb begin
    run_n = en_r;
    cnt_n = cnt_q;
    tgl_n = tgl_q;
    if (!en_r) begin
      cnt_n = '0;
    end else if (cnt_q >= last) begin
      cnt_n = '0;
      tgl_n = ~tgl_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
      tgl_q <= tgl_n;
    end
  end

  assign run     = run_q;
  assign win_tgl = tgl_q;
endmodule

// File: rtl/fm_edge_counter.sv
// Monitored-domain saturating edge counter with capture on each window boundary.
module fm_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             mon_clk,
  input  logic             mon_rst_n,
  input  logic             run_async,
  input  logic             tgl_async,
  output logic [CNT_W-1:0] count_hold,
  output logic             cap_tgl,
  output logic [CNT_W-1:0] live_cnt,
  output logic             live_run,
  output logic             live_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       s_m;
  logic             run_m, tgl_m, evt;
  logic             tgl_d_q, tgl_d_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, hold_q, hold_n;
  logic             cap_q, cap_n;

  fm_sync #(.W(2)) u_in_sync (
    .clk(mon_clk), .rst_n(mon_rst_n), .d({run_async, tgl_async}), .q(s_m)
  );

  assign run_m = s_m[1];
  assign tgl_m = s_m[0];
  assign evt   = tgl_m ^ tgl_d_q;

  always_comb begin
    tgl_d_n = tgl_m;
    cnt_n   = cnt_q;
    hold_n  = hold_q;
    cap_n   = cap_q;
    if (!run_m) begin
      cnt_n = '0;
    end else if (evt) begin
      hold_n = cnt_q;
      cnt_n  = {{(CNT_W-1){1'b0}}, 1'b1};
      cap_n  = ~cap_q;
    end else if (cnt_q != CNT_MAX) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      tgl_d_q <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
      cap_q   <= 1'b0;
    end else begin
      tgl_d_q <= tgl_d_n;
      cnt_q   <= cnt_n;
      hold_q  <= hold_n;
      cap_q   <= cap_n;
    end
  end

  assign count_hold = hold_q;
  assign cap_tgl    = cap_q;
  assign live_cnt   = cnt_q;
  assign live_run   = run_m;
  assign live_evt   = evt;
endmodule

// File: rtl/clk_freq_monitor.sv
module clk_freq_monitor
  import fm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REF_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              mon_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_sync,
  output logic              irq_async,
  output logic [1:0]        freq_state
);
  logic bus_rst_n, ref_rst_n, mon_rst_n;

  fm_rst_sync u_rst_bus (.clk(clk),     .rst_n_in(rst_n), .rst_n_out(bus_rst_n));
  fm_rst_sync u_rst_ref (.clk(ref_clk), .rst_n_in(rst_n), .rst_n_out(ref_rst_n));
  fm_rst_sync u_rst_mon (.clk(mon_clk), .rst_n_in(rst_n), .rst_n_out(mon_rst_n));

  // Bus-domain register state
  logic              en_q, en_n;
  logic [REF_W-1:0]  win_q, win_n;
  logic [CNT_W-1:0]  hi_q, hi_n, lo_q, lo_n;
  logic [MASK_W-1:0] mask_q, mask_n;
  logic [FLAG_W-1:0] flag_q, flag_n, clr;
  logic              irq_s_q, irq_s_n;
  logic              cap_d_q;

  // Cross-domain wires
  logic             run_ref, win_tgl;
  logic [CNT_W-1:0] cnt_hold;
  logic             cap_tgl;
  logic [CNT_W-1:0] mon_cnt;
  logic             mon_run, mon_evt;
  logic [1:0]       s_b;
  logic             run_b, cap_b, cap_evt;

  fm_ref_timer #(.REF_W(REF_W)) u_timer (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .en_async(en_q),
    .win_len(win_q), .run(run_ref), .win_tgl(win_tgl)
  );

  fm_edge_counter #(.CNT_W(CNT_W)) u_edge (
    .mon_clk(mon_clk), .mon_rst_n(mon_rst_n), .run_async(run_ref),
    .tgl_async(win_tgl), .count_hold(cnt_hold), .cap_tgl(cap_tgl),
    .live_cnt(mon_cnt), .live_run(mon_run), .live_evt(mon_evt)
  );

  fm_sync #(.W(2)) u_bus_sync (
    .clk(clk), .rst_n(bus_rst_n), .d({run_ref, cap_tgl}), .q(s_b)
  );

  assign run_b   = s_b[1];
  assign cap_b   = s_b[0];
  assign cap_evt = cap_b ^ cap_d_q;

  logic wr_hit, wr_status, set_hi, set_lo;
  logic hi_seen, lo_seen;

  assign wr_hit    = bus_sel & bus_wr;
  assign wr_status = wr_hit & (bus_addr == ADDR_STATUS);
  // The held count is stable: it changed at least two bus cycles before cap_evt.
  assign set_hi    = en_q & cap_evt & (cnt_hold > hi_q);
  assign set_lo    = en_q & cap_evt & (cnt_hold < lo_q);

  always_comb begin
    en_n   = en_q;
    win_n  = win_q;
    hi_n   = hi_q;
    lo_n   = lo_q;
    mask_n = mask_q;
    clr    = '0;
    if (wr_hit) begin
      case (fm_addr_e'(bus_addr))
        ADDR_CTRL:   en_n   = bus_wdata[0];
        ADDR_WINDOW: win_n  = bus_wdata[REF_W-1:0];
        ADDR_HI:     hi_n   = bus_wdata[CNT_W-1:0];
        ADDR_LO:     lo_n   = bus_wdata[CNT_W-1:0];
        ADDR_MASK:   mask_n = bus_wdata[MASK_W-1:0];
        ADDR_STATUS: clr    = bus_wdata[FLAG_W-1:0];
        default: ;
      endcase
    end
    // A new result in the same cycle wins over a clear.
    flag_n  = (flag_q & ~clr) | {set_hi, set_lo};
    irq_s_n = |(flag_q & mask_q[1:0]);
  end

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      en_q    <= 1'b0;
      win_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      mask_q  <= '0;
      flag_q  <= '0;
      irq_s_q <= 1'b0;
      cap_d_q <= 1'b0;
    end else begin
      en_q    <= en_n;
      win_q   <= win_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      mask_q  <= mask_n;
      flag_q  <= flag_n;
      irq_s_q <= irq_s_n;
      cap_d_q <= cap_b;
    end
  end

  always_comb begin
    case (fm_addr_e'(bus_addr))
      ADDR_CTRL:   bus_rdata = DATA_W'(en_q);
      ADDR_WINDOW: bus_rdata = DATA_W'(win_q);
      ADDR_HI:     bus_rdata = DATA_W'(hi_q);
      ADDR_LO:     bus_rdata = DATA_W'(lo_q);
      ADDR_MASK:   bus_rdata = DATA_W'(mask_q);
      ADDR_STATUS: bus_rdata = DATA_W'({run_b, flag_q});
      default:     bus_rdata = '0;
    endcase
  end

  assign hi_seen   = flag_q[FLAG_HI] & (mask_q[1] | mask_q[3]);
  assign lo_seen   = flag_q[FLAG_LO] & (mask_q[0] | mask_q[2]);
  assign irq_sync  = irq_s_q;
  assign irq_async = (flag_q[FLAG_LO] & mask_q[2]) | (flag_q[FLAG_HI] & mask_q[3]);

  always_comb begin
    if (!en_q)        freq_state = ST_OFF;
    else if (hi_seen) freq_state = ST_HIGH;
    else if (lo_seen) freq_state = ST_LOW;
    else              freq_state = ST_IN_RANGE;
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mon_clk,
  input logic             mon_rst_n,
  input logic             wr_status,
  input logic [1:0]       wdata_flags,
  input logic             cap_evt,
  input logic             en_q,
  input logic [1:0]       flag_q,
  input logic [3:0]       mask_q,
  input logic             irq_sync,
  input logic             irq_async,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_run,
  input logic             cnt_evt
);
  p_hi_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !(wr_status && wdata_flags[1])) |=> flag_q[1]);

  p_lo_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(wr_status && wdata_flags[0])) |=> flag_q[0]);

  p_hi_from_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(cap_evt && en_q));

  p_lo_from_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(cap_evt && en_q));

  p_w1c_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wdata_flags[0] && !cap_evt) |=> !flag_q[0]);

  p_async_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[3:2] == 2'b00) |-> !irq_async);

  p_sync_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q[1:0] == 2'b00) && ($past(mask_q[1:0]) == 2'b00)) |-> !irq_sync);

  p_saturate_r7: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    (cnt_run && !cnt_evt && (cnt_val == {CNT_W{1'b1}})) |=> (cnt_val == {CNT_W{1'b1}}));
endmodule

bind clk_freq_monitor fm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(bus_rst_n), .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
  .wr_status(wr_status), .wdata_flags(bus_wdata[1:0]), .cap_evt(cap_evt),
  .en_q(en_q), .flag_q(flag_q), .mask_q(mask_q), .irq_sync(irq_sync),
  .irq_async(irq_async), .cnt_val(mon_cnt), .cnt_run(mon_run), .cnt_evt(mon_evt)
);

// File: tb/sim_clk_freq_monitor.sv
`timescale 1ns/1ps
module sim_clk_freq_monitor;
  localparam int CW = 7;

  logic clk, rst_n, ref_clk, mon_clk;
  logic bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq_sync, irq_async;
  logic [1:0] freq_state;

  int mon_half = 20;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  clk_freq_monitor #(.DATA_W(32), .REF_W(16), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .mon_clk(mon_clk),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sync(irq_sync),
    .irq_async(irq_async), .freq_state(freq_state)
  );

  initial clk = 0;
  always #10 clk = ~clk;           // 50 MHz bus clock
  initial ref_clk = 0;
  always #50 ref_clk = ~ref_clk;   // 100 ns reference period
  initial mon_clk = 0;
  always #(mon_half) mon_clk = ~mon_clk;

  // half period, window, high limit, low limit, expected flags, expected state
  localparam int VEC [7][6] = '{
    '{20, 20,  55, 45, 0, 1},
    '{10, 20,  55, 45, 2, 3},
    '{40, 20,  55, 45, 1, 2},
    '{20, 20,  40, 30, 2, 3},
    '{20, 20,  70, 60, 1, 2},
    '{ 5, 20, 120, 45, 2, 3},
    '{20, 40, 110, 90, 0, 1}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_run(input logic want, output logic got);
    logic [31:0] s;
    got = ~want;
    for (int k = 0; k < 200; k++) begin
      rd(3'd5, s);
      got = s[2];
      if (got == want) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic r;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);

    // Reset state (R10)
    rd(3'd0, d); chk("R10", "ctrl after reset", d, 0);
    rd(3'd5, d); chk("R10", "status after reset", d, 0);
    rd(3'd4, d); chk("R10", "mask after reset", d, 0);
    chk("R10", "state after reset", {30'd0, freq_state}, 0);
    chk("R10", "irqs after reset", {30'd0, irq_sync, irq_async}, 0);
    wr(3'd2, 32'd55); rd(3'd2, d); chk("R10", "high limit readback", d, 55);
    wr(3'd1, 32'd20); rd(3'd1, d); chk("R10", "window readback", d, 20);

    // Table walk
    for (int i = 0; i < 7; i++) begin
      string tag;
      tag = (i == 5) ? "R7" : (i == 6) ? "R2" :
            (VEC[i][4] == 2) ? "R3" : "R4";
      mon_half = VEC[i][0];
      wr(3'd1, VEC[i][1]);
      wr(3'd2, VEC[i][2]);
      wr(3'd3, VEC[i][3]);
      wr(3'd4, 32'h3);
      wr(3'd0, 32'h1);
      wait_run(1'b1, r);
      chk("R1", "running after enable", {31'd0, r}, 1);
      repeat (VEC[i][1] * 15) @(negedge clk);
      chk("R9", "state while enabled", {30'd0, freq_state}, VEC[i][5]);
      chk("R8", "irq_sync", {31'd0, irq_sync}, (VEC[i][4] != 0) ? 1 : 0);
      wr(3'd0, 32'h0);
      wait_run(1'b0, r);
      chk("R1", "running after disable", {31'd0, r}, 0);
      rd(3'd5, d);
      chk(tag, "flags after window", d & 3, VEC[i][4]);
      wr(3'd5, d);
      rd(3'd5, d);
      chk("R5", "flags after write-back", d, 0);
    end

    // Masking and verdict (R8, R9), stickiness (R6)
    mon_half = 10;
    wr(3'd1, 20); wr(3'd2, 55); wr(3'd3, 45); wr(3'd4, 0);
    wr(3'd0, 1);
    wait_run(1'b1, r);
    repeat (300) @(negedge clk);
    chk("R9", "state with flag masked", {30'd0, freq_state}, 1);
    chk("R8", "irqs with mask clear", {30'd0, irq_sync, irq_async}, 0);
    wr(3'd4, 32'h8);
    repeat (3) @(negedge clk);
    chk("R9", "state with async high enable", {30'd0, freq_state}, 3);
    chk("R8", "irq_async on", {31'd0, irq_async}, 1);
    chk("R8", "irq_sync off", {31'd0, irq_sync}, 0);
    wr(3'd0, 0);
    wait_run(1'b0, r);
    chk("R9", "state when disabled", {30'd0, freq_state}, 0);
    rd(3'd5, d); chk("R6", "high flag kept over disable", d, 2);

    // Both flags: priority (R9) and partial clear (R5)
    mon_half = 40;
    wr(3'd2, 127); wr(3'd3, 60); wr(3'd4, 3);
    wr(3'd0, 1);
    wait_run(1'b1, r);
    repeat (300) @(negedge clk);
    chk("R9", "high wins over low", {30'd0, freq_state}, 3);
    wr(3'd0, 0);
    wait_run(1'b0, r);
    rd(3'd5, d); chk("R4", "both flags set", d, 3);
    wr(3'd5, 1); rd(3'd5, d); chk("R5", "clear low only", d, 2);
    wr(3'd5, 0); rd(3'd5, d); chk("R5", "zero write keeps flag", d, 2);
    wr(3'd5, 2); rd(3'd5, d); chk("R5", "clear high", d, 0);

    // Disabled: fast clock must not set a flag (R6)
    mon_half = 10;
    repeat (300) @(negedge clk);
    rd(3'd5, d); chk("R6", "no flag while disabled", d, 0);

    finish_run();
  end
endmodule